// File: doc/BRIEF.md
# Armable Autowake Sleep Timer

This block wakes the chip from a low-power state after a programmed delay. Software writes a 3-bit period and a 1-bit resolution select through a small register port. Software then arms the timer with a write strobe. Arming takes a working copy of the period and resolution. From then on the countdown depends only on that copy, and later register writes do not affect it.

A slow time-base tick, nominally 2 Hz, drives the count. An internal prescaler turns ticks into units of 2.5 s (5 ticks) or 1 minute (120 ticks). A sleep request starts the countdown only if the timer has been armed for at least three slow ticks. A request that comes earlier sets a sticky too-late status bit and disarms the timer.

The countdown advances only while the operating mode is sleep or display-only. When the countdown expires, the block emits a single-cycle wake pulse. A return to the active or brownout mode from a low-power mode clears and disarms the timer.

Top module: `wt_top`

## Requirements
- R1: After synchronous reset the period field reads 1, resolution reads 0, armed and too-late read 0, and wake is low.
- R2: A register write with reg_wr high stores reg_wdata[2:0] as period and reg_wdata[3] as resolution. reg_rdata returns period on [2:0], resolution on [3], the too-late flag on [4] and the armed status on [5].
- R3: A write with reg_wdata[5]=1 arms the timer and loads the period and resolution written in that same write. Later writes that do not arm do not change a loaded countdown.
- R4: The wake time, counted in ticks after an accepted sleep request, is period × 5 for resolution 0 and period × 120 for resolution 1. Wake is high in the cycle after the clock edge that samples the final tick.
- R5: A period of 0 gives the same wake time as a period of 1, which is one unit.
- R6: A sleep_req pulse that arrives while armed but fewer than three ticks after arming sets the too-late flag, disarms the timer and starts no countdown.
- R7: The too-late flag stays set until a write with reg_wdata[4]=1 clears it.
- R8: A change of mode from sleep (2'b10) or display-only (2'b11) to active (2'b00) or brownout (2'b01) disarms the timer and stops any countdown, so no wake follows.
- R9: Wake is a single-cycle pulse that also disarms the timer. The countdown advances only while mode[1]=1.
- R10: Arming during a running countdown restarts it from the freshly loaded values, with the prescaler reset.
- R11: A sleep_req while not armed has no effect: the timer stays disarmed and no wake occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per slow time-base period |
| mode | input | 2 | Operating mode: 00 active, 01 brownout, 10 sleep, 11 display-only |
| sleep_req | input | 1 | One-cycle request to enter a low-power mode |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 6 | Write data: [2:0] period, [3] resolution, [4] clear too-late, [5] arm |
| reg_rdata | output | 6 | Read data: [2:0] period, [3] resolution, [4] too-late, [5] armed |
| wake | output | 1 | Single-cycle wake pulse |

## Verification
The assertions check the following on every cycle:
- a wake pulse is never longer than one cycle;
- wake comes only right after a tick seen in a low-power mode;
- the timer is disarmed whenever wake is high;
- an arm write leaves the timer armed;
- a return to active or brownout disarms it;
- the too-late flag holds until a clear write.

The exact number of ticks to wake for each period and resolution pair needs the bench's scenarios. So do the freezing of loaded values against later writes, the three-tick arming margin, the pause of counting in active mode, and the restart on re-arm.

// File: rtl/wt_pkg.sv
package wt_pkg;

    localparam int PERIOD_W = 3;

    // register port bit positions
    localparam int RES_BIT   = 3;
    localparam int LATE_BIT  = 4;
    localparam int ARM_BIT   = 5;
    localparam int REG_W     = 6;

    typedef enum logic [1:0] {
        MODE_ACTIVE   = 2'b00,
        MODE_BROWNOUT = 2'b01,
        MODE_SLEEP    = 2'b10,
        MODE_DISPLAY  = 2'b11
    } wt_mode_e;

    typedef struct packed {
        logic                res;
        logic [PERIOD_W-1:0] period;
    } wt_cfg_t;

    function automatic logic is_low_power(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic int unsigned unit_len(input logic res,
                                             input int unsigned short_ticks,
                                             input int unsigned long_ticks);
        return res ? long_ticks : short_ticks;
    endfunction

endpackage

// File: rtl/wt_cfg_regs.sv
module wt_cfg_regs
    import wt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [REG_W-1:0] wdata,
    output wt_cfg_t         cfg_q,
    output wt_cfg_t         cfg_next,
    output logic            arm_load,
    output logic            late_clr
);
    wt_cfg_t wr_cfg;

    always_comb begin
        wr_cfg.period = wdata[PERIOD_W-1:0];
        wr_cfg.res    = wdata[RES_BIT];
        cfg_next      = wr_en ? wr_cfg : cfg_q;
        arm_load      = wr_en && wdata[ARM_BIT];
        late_clr      = wr_en && wdata[LATE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.period <= PERIOD_W'(1);
            cfg_q.res    <= 1'b0;
        end else if (wr_en) begin
            cfg_q <= wr_cfg;
        end
    end
endmodule

// File: rtl/wt_arm_guard.sv
module wt_arm_guard #(
    parameter int MIN_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic arm_load,
    input  logic late_clr,
    input  logic tick,
    input  logic sleep_req,
    input  logic running,
    input  logic done,
    output logic armed,
    output logic late,
    output logic start
);
    localparam int CNT_W = $clog2(MIN_TICKS + 1);

    logic [CNT_W-1:0] since_arm;
    logic             margin_ok;
    logic             req_valid;
    logic             too_late;

    always_comb begin
        margin_ok = (since_arm >= CNT_W'(MIN_TICKS));
        req_valid = sleep_req && armed && !running && !arm_load && !clear;
        start     = req_valid && margin_ok;
        too_late  = req_valid && !margin_ok;
    end

    always_ff @(posedge clk) begin
        if (rst || clear || arm_load) begin
            since_arm <= '0;
        end else if (tick && armed && !margin_ok) begin
            since_arm <= since_arm + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed <= 1'b0;
        end else if (arm_load) begin
            armed <= 1'b1;
        end else if (too_late || done) begin
            armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            late <= 1'b0;
        end else if (too_late) begin
            late <= 1'b1;
        end else if (late_clr) begin
            late <= 1'b0;
        end
    end
endmodule

// File: rtl/wt_countdown.sv
module wt_countdown
    import wt_pkg::*;
#(
    parameter int SHORT_TICKS = 5,
    parameter int LONG_TICKS  = 120
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    load,
    input  wt_cfg_t cfg_load,
    input  logic    start,
    input  logic    tick,
    input  logic    low_power,
    output logic    running,
    output logic    done,
    output logic    wake
);
    localparam int MAXT  = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int PRE_W = $clog2(MAXT + 1);

    logic [PRE_W-1:0]    pre;
    logic [PERIOD_W-1:0] units;
    logic                res_w;
    logic                at_bound;
    logic                step;

    always_comb begin
        at_bound = (pre == PRE_W'(unit_len(res_w, SHORT_TICKS, LONG_TICKS) - 1));
        step     = running && tick && low_power && !load && !clear;
        done     = step && at_bound && (units <= PERIOD_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            running <= 1'b0;
            pre     <= '0;
            units   <= '0;
            res_w   <= 1'b0;
            wake    <= 1'b0;
        end else begin
            wake <= done;
            if (load) begin
                units <= cfg_load.period;
                res_w <= cfg_load.res;
                pre   <= '0;
            end else if (start) begin
                running <= 1'b1;
                pre     <= '0;
            end else if (step) begin
                if (at_bound) begin
                    pre <= '0;
                    if (done) running <= 1'b0;
                    else      units   <= units - 1'b1;
                end else begin
                    pre <= pre + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wt_top.sv
module wt_top
    import wt_pkg::*;
#(
    parameter int SHORT_TICKS = 5,
    parameter int LONG_TICKS  = 120,
    parameter int MIN_TICKS   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] mode,
    input  logic       sleep_req,
    input  logic       reg_wr,
    input  logic [5:0] reg_wdata,
    output logic [5:0] reg_rdata,
    output logic       wake
);
    wt_cfg_t cfg_q, cfg_next;
    logic    arm_load, late_clr;
    logic    armed, late, start, running, done;
    logic    lp_prev, clear;

    always_ff @(posedge clk) lp_prev <= is_low_power(mode);

    assign clear = !is_low_power(mode) && lp_prev;

    wt_cfg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wdata(reg_wdata),
        .cfg_q(cfg_q), .cfg_next(cfg_next), .arm_load(arm_load), .late_clr(late_clr)
    );

    wt_arm_guard #(.MIN_TICKS(MIN_TICKS)) u_guard (
        .clk(clk), .rst(rst), .clear(clear), .arm_load(arm_load), .late_clr(late_clr),
        .tick(tick), .sleep_req(sleep_req), .running(running), .done(done),
        .armed(armed), .late(late), .start(start)
    );

    wt_countdown #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_cnt (
        .clk(clk), .rst(rst), .clear(clear), .load(arm_load), .cfg_load(cfg_next),
        .start(start), .tick(tick), .low_power(is_low_power(mode)),
        .running(running), .done(done), .wake(wake)
    );

    assign reg_rdata = {armed, late, cfg_q.res, cfg_q.period};
endmodule

// File: rtl/wt_checker.sv
module wt_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [1:0] mode,
    input logic       reg_wr,
    input logic [5:0] reg_wdata,
    input logic [5:0] reg_rdata,
    input logic       wake
);
    a_r9_wake_single: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    a_r9_wake_disarms: assert property (@(posedge clk) disable iff (rst)
        wake |-> !reg_rdata[5]);

    a_r9_wake_low_power: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(mode[1]));

    a_r4_wake_after_tick: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(tick));

    a_r3_arm_sets: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[5] && !(!mode[1] && $past(mode[1]))) |=> reg_rdata[5]);

    a_r8_entry_disarms: assert property (@(posedge clk) disable iff (rst)
        (!mode[1] && $past(mode[1])) |=> !reg_rdata[5]);

    a_r7_late_sticky: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[4] && !(reg_wr && reg_wdata[4])) |=> reg_rdata[4]);
endmodule

bind wt_top wt_checker u_chk (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake(wake)
);

// File: tb/wt_top_test.sv
`timescale 1ns/1ps
module wt_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       sleep_req = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic       wake;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    wt_top uut (.*);

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [2:0]  p;
        logic        r;
        logic [11:0] n;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'd1, 1'b0, 12'd5},   '{3'd3, 1'b0, 12'd15},
        '{3'd7, 1'b0, 12'd35},  '{3'd0, 1'b0, 12'd5},
        '{3'd2, 1'b1, 12'd240}, '{3'd7, 1'b1, 12'd840},
        '{3'd0, 1'b1, 12'd120}, '{3'd5, 1'b0, 12'd25}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse_req();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    // one tick; returns wake observed after it
    task automatic do_tick(output logic w);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        w = wake;
    endtask

    task automatic ticks_to_wake(input int max, output int n);
        logic w;
        n = -1;
        for (int i = 1; i <= max; i++) begin
            do_tick(w);
            if (w) begin
                n = i;
                @(negedge clk);
                chk("R9 single pulse", int'(wake), 0);
                return;
            end
        end
    endtask

    task automatic arm_and_sleep(input logic [2:0] p, input logic r);
        logic w;
        wr({1'b1, 1'b0, r, p});
        for (int i = 0; i < 3; i++) do_tick(w);
        mode = 2'b10;
        pulse_req();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 period", int'(reg_rdata[2:0]), 1);
        chk("R1 res", int'(reg_rdata[3]), 0);
        chk("R1 late", int'(reg_rdata[4]), 0);
        chk("R1 armed", int'(reg_rdata[5]), 0);
        chk("R1 wake", int'(wake), 0);

        // R2 readback
        wr(6'b00_1_110);
        chk("R2 readback", int'(reg_rdata), 6'b00_1_110);

        // R4 / R5 vector table
        foreach (VEC[k]) begin
            arm_and_sleep(VEC[k].p, VEC[k].r);
            ticks_to_wake(1000, n);
            chk((VEC[k].p == 0) ? "R5 period zero" : "R4 wake time", n, int'(VEC[k].n));
            chk("R9 disarmed after wake", int'(reg_rdata[5]), 0);
            mode = 2'b00;
            @(negedge clk);
        end

        // R3 loaded copy frozen against later writes
        wr({1'b1, 1'b0, 1'b0, 3'd2});
        wr({1'b0, 1'b0, 1'b1, 3'd7});
        chk("R3 armed", int'(reg_rdata[5]), 1);
        begin
            logic w;
            for (int i = 0; i < 3; i++) do_tick(w);
        end
        mode = 2'b10;
        pulse_req();
        ticks_to_wake(1000, n);
        chk("R3 frozen count", n, 10);
        mode = 2'b00;
        @(negedge clk);

        // R6 too-late request
        wr({1'b1, 1'b0, 1'b0, 3'd1});
        begin
            logic w;
            do_tick(w); do_tick(w);
        end
        mode = 2'b10;
        pulse_req();
        chk("R6 late set", int'(reg_rdata[4]), 1);
        chk("R6 disarmed", int'(reg_rdata[5]), 0);
        ticks_to_wake(40, n);
        chk("R6 no wake", n, -1);
        mode = 2'b00;
        @(negedge clk);

        // R7 sticky until clear
        wr({1'b0, 1'b0, 1'b0, 3'd1});
        chk("R7 sticky", int'(reg_rdata[4]), 1);
        wr({1'b0, 1'b1, 1'b0, 3'd1});
        chk("R7 cleared", int'(reg_rdata[4]), 0);

        // R8 return to active disarms
        arm_and_sleep(3'd2, 1'b0);
        begin
            logic w;
            do_tick(w); do_tick(w);
        end
        mode = 2'b01;
        @(negedge clk);
        @(negedge clk);
        chk("R8 disarmed", int'(reg_rdata[5]), 0);
        mode = 2'b11;
        ticks_to_wake(40, n);
        chk("R8 no wake", n, -1);
        mode = 2'b00;
        @(negedge clk);

        // R9 counting paused in active mode
        wr({1'b1, 1'b0, 1'b0, 3'd1});
        begin
            logic w;
            for (int i = 0; i < 3; i++) do_tick(w);
        end
        pulse_req();
        ticks_to_wake(10, n);
        chk("R9 paused in active", n, -1);
        mode = 2'b10;
        ticks_to_wake(100, n);
        chk("R9 resumes in sleep", n, 5);
        mode = 2'b00;
        @(negedge clk);

        // R10 re-arm restarts
        arm_and_sleep(3'd4, 1'b0);
        begin
            logic w;
            for (int i = 0; i < 7; i++) do_tick(w);
        end
        wr({1'b1, 1'b0, 1'b0, 3'd1});
        ticks_to_wake(100, n);
        chk("R10 restart", n, 5);
        mode = 2'b00;
        @(negedge clk);

        // R11 request while disarmed ignored
        mode = 2'b10;
        pulse_req();
        chk("R11 stays disarmed", int'(reg_rdata[5]), 0);
        ticks_to_wake(40, n);
        chk("R11 no wake", n, -1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule